// File: doc/BRIEF.md
# Multiprocessor-Framing UART Transmitter with Idle-Gap Insertion

This block is the transmit half of a serial port used on a shared line that links several nodes. Software loads one character at a time into a holding register. The character moves into a shift register as soon as the shift register is free, and it goes out least significant bit first, with one low start bit and one high stop bit. Each bit lasts one period of an external baud tick, and the line rests high whenever nothing is being sent.

To mark the start of a new block of messages, software sets a wake control bit and then writes any value to the holding register. The line is one-directional, and receive logic is outside this block.

- **Idle-line framing:** the dummy write does not produce a character. The transmitter instead keeps the line high for a fixed number of bit periods, so that listeners can tell the following character is an address.
- **Address-bit framing:** every character carries one extra bit between the data and the stop bit. That bit takes the value of the wake bit at the moment of transfer.

In both framings the wake bit clears on the same clock edge on which the holding register empties. A transmit interrupt pulses on that edge, so software can wait for the interrupt instead of polling the wake bit.

Top module: `wkgap_uart_tx`

## Requirements
- R1: After reset the serial output is high, `tx_ready` is high, `tx_irq` is low and `wake_q` is low.
- R2: In idle-line framing (`addr_mode`=0) a character is sent as DATA_W+2 bit periods: position 0 is a low start bit, positions 1..DATA_W are the data least significant bit first, and position DATA_W+1 is a high stop bit. The serial output changes only on the clock edge that follows a cycle with `baud_tick` high.
- R3: `tx_ready` goes low on the edge that accepts a write and stays low until the transfer to the shift register. A write made while `tx_ready` is low is dropped, and its value never appears on the line.
- R4: On the transfer edge, `tx_ready` rises and `wake_q` clears together. `tx_irq` is high for exactly the one cycle after that edge if `irq_en` was high, and it stays low otherwise.
- R5: In idle-line framing, a transfer taken while `wake_q` is 1 sends no character. The line stays high for IDLE_BITS full bit periods counted from the end of the previous stop bit (or from the transfer when the line was already idle). The dummy value never appears on the line.
- R6: A character that is waiting in the holding register begins its start bit on the same tick that ends the previous stop bit or idle gap. No extra idle period is inserted.
- R7: In address-bit framing (`addr_mode`=1) a character is DATA_W+3 bit periods long. Position DATA_W+1 carries the wake bit value at transfer time, position DATA_W+2 is the stop bit, and `wake_q` then reads 0.
- R8: If software writes the wake bit on the same edge as a transfer, the software value is kept. The transfer uses the value the wake bit held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse that marks each bit-period boundary |
| addr_mode | input | 1 | 0 selects idle-line framing, 1 selects address-bit framing |
| irq_en | input | 1 | Enables the transmit interrupt pulse |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| wake_wr_en | input | 1 | Write strobe for the wake bit |
| wake_wr_val | input | 1 | Value written to the wake bit |
| tx_ready | output | 1 | High when the holding register can accept a write |
| wake_q | output | 1 | Current wake bit |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |
| txd | output | 1 | Serial output, high when idle |

## Verification
The hardware clear of the wake bit at transfer and a software write of the wake bit can land on the same clock edge. The bench provokes this in address-bit framing. It writes a character while the shifter is idle, so the transfer takes place on the next edge, and it raises the wake-bit write strobe in exactly that cycle. It then judges the outcome by three results: the wake bit must read back 1, the first character must carry address bit 0, and a second, queued character must carry address bit 1, after which the wake bit must read 0.

// File: rtl/wkgap_pkg.sv
package wkgap_pkg;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_ARM  = 2'd1,
      S_DATA = 2'd2,
      S_GAP  = 2'd3
   } tx_state_e;

   localparam int MIN_IDLE_BITS = 10;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int frame_width(input int dw);
      return dw + 3;
   endfunction

endpackage

// File: rtl/wkgap_frame_build.sv
module wkgap_frame_build #(
   parameter int DATA_W  = 8,
   parameter int ADDR_EN = 1,
   parameter int FRAME_W = DATA_W + 3,
   parameter int CNT_W   = 4
) (
   input  logic [DATA_W-1:0]  data,
   input  logic               wake,
   input  logic               addr_mode,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   len_m1,
   output logic               gap_req
);

   logic mode_eff;

   generate
      if (ADDR_EN != 0) begin : g_addr
         assign mode_eff = addr_mode;
      end else begin : g_noaddr
         logic unused_mode;
         assign unused_mode = addr_mode;
         assign mode_eff    = 1'b0;
      end
   endgenerate

   always_comb begin
      frame            = '1;
      frame[0]         = 1'b0;
      frame[DATA_W:1]  = data;
      if (mode_eff) begin
         frame[DATA_W+1] = wake;
      end
   end

   assign len_m1  = mode_eff ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);
   assign gap_req = wake & ~mode_eff;

endmodule

// File: rtl/wkgap_hold_reg.sv
module wkgap_hold_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wake_wr_en,
   input  logic              wake_wr_val,
   input  logic              irq_en,
   input  logic              xfer,
   output logic [DATA_W-1:0] hold_data,
   output logic              hold_full,
   output logic              wake_q,
   output logic              tx_ready,
   output logic              tx_irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
      end else if (xfer) begin
         hold_full <= 1'b0;
      end else if (wr_en && !hold_full) begin
         hold_full <= 1'b1;
         hold_data <= wr_data;
      end
   end

   // A software write of the wake bit takes priority over the clear on transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_q <= 1'b0;
      end else if (wake_wr_en) begin
         wake_q <= wake_wr_val;
      end else if (xfer) begin
         wake_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_irq <= 1'b0;
      end else begin
         tx_irq <= xfer & irq_en;
      end
   end

   assign tx_ready = ~hold_full;

endmodule

// File: rtl/wkgap_shifter.sv
module wkgap_shifter
   import wkgap_pkg::*;
#(
   parameter int IDLE_BITS = 10,
   parameter int FRAME_W   = 11,
   parameter int CNT_W     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               baud_tick,
   input  logic               hold_full,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   len_m1,
   input  logic               gap_req,
   output logic               xfer,
   output logic               txd,
   output logic               gap_busy
);

   localparam logic [CNT_W-1:0] GAP_M1 = CNT_W'(IDLE_BITS - 1);

   tx_state_e          st;
   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   rem;
   logic               end_ev;

   assign end_ev   = baud_tick && (rem == '0) && (st == S_DATA || st == S_GAP);
   assign xfer     = hold_full && (st == S_IDLE || end_ev);
   assign gap_busy = (st == S_GAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= S_IDLE;
         txd <= 1'b1;
         sh  <= '1;
         rem <= '0;
      end else if (xfer) begin
         if (gap_req) begin
            st  <= S_GAP;
            rem <= GAP_M1;
            txd <= 1'b1;
         end else if (st == S_IDLE) begin
            st  <= S_ARM;
            sh  <= frame;
            rem <= len_m1;
         end else begin
            st  <= S_DATA;
            txd <= frame[0];
            sh  <= {1'b1, frame[FRAME_W-1:1]};
            rem <= len_m1;
         end
      end else begin
         unique case (st)
            S_ARM: begin
               if (baud_tick) begin
                  txd <= sh[0];
                  sh  <= {1'b1, sh[FRAME_W-1:1]};
                  st  <= S_DATA;
               end
            end
            S_DATA: begin
               if (baud_tick) begin
                  if (rem == '0) begin
                     st  <= S_IDLE;
                     txd <= 1'b1;
                  end else begin
                     txd <= sh[0];
                     sh  <= {1'b1, sh[FRAME_W-1:1]};
                     rem <= rem - 1'b1;
                  end
               end
            end
            S_GAP: begin
               if (baud_tick) begin
                  if (rem == '0) begin
                     st <= S_IDLE;
                  end else begin
                     rem <= rem - 1'b1;
                  end
               end
            end
            default: begin
               txd <= 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/wkgap_uart_tx.sv
module wkgap_uart_tx
   import wkgap_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int IDLE_BITS = 10,
   parameter int ADDR_EN   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              addr_mode,
   input  logic              irq_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wake_wr_en,
   input  logic              wake_wr_val,
   output logic              tx_ready,
   output logic              wake_q,
   output logic              tx_irq,
   output logic              txd
);

   localparam int FRAME_W = frame_width(DATA_W);
   localparam int CNT_W   = $clog2(max_int(FRAME_W, IDLE_BITS) + 1);

   generate
      if (DATA_W < 1 || DATA_W > 16) begin : g_bad_width
         $error("wkgap_uart_tx: DATA_W must lie in 1..16");
      end
      if (IDLE_BITS < MIN_IDLE_BITS) begin : g_bad_idle
         $error("wkgap_uart_tx: IDLE_BITS below the minimum idle gap");
      end
      if (ADDR_EN != 0 && ADDR_EN != 1) begin : g_bad_addr
         $error("wkgap_uart_tx: ADDR_EN must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0]  hold_data;
   logic               hold_full;
   logic               xfer;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   len_m1;
   logic               gap_req;
   logic               gap_busy;

   wkgap_hold_reg #(
      .DATA_W (DATA_W)
   ) hold_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .wake_wr_en  (wake_wr_en),
      .wake_wr_val (wake_wr_val),
      .irq_en      (irq_en),
      .xfer        (xfer),
      .hold_data   (hold_data),
      .hold_full   (hold_full),
      .wake_q      (wake_q),
      .tx_ready    (tx_ready),
      .tx_irq      (tx_irq)
   );

   wkgap_frame_build #(
      .DATA_W  (DATA_W),
      .ADDR_EN (ADDR_EN),
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W)
   ) build_i (
      .data      (hold_data),
      .wake      (wake_q),
      .addr_mode (addr_mode),
      .frame     (frame),
      .len_m1    (len_m1),
      .gap_req   (gap_req)
   );

   wkgap_shifter #(
      .IDLE_BITS (IDLE_BITS),
      .FRAME_W   (FRAME_W),
      .CNT_W     (CNT_W)
   ) shift_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .hold_full (hold_full),
      .frame     (frame),
      .len_m1    (len_m1),
      .gap_req   (gap_req),
      .xfer      (xfer),
      .txd       (txd),
      .gap_busy  (gap_busy)
   );

endmodule

// File: rtl/wkgap_uart_tx_chk.sv
module wkgap_uart_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic wr_en,
   input logic wake_wr_en,
   input logic irq_en,
   input logic tx_ready,
   input logic wake_q,
   input logic tx_irq,
   input logic txd,
   input logic gap_busy
);

   AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> $past(baud_tick)); // R2

   AST_READY_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_ready) |-> $past(wr_en)); // R3

   AST_WAKE_CLEAR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ready) |-> (!wake_q || $past(wake_wr_en))); // R4

   AST_WAKE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wake_q) |-> ($past(wake_wr_en) || $rose(tx_ready))); // R4

   AST_IRQ_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> ($rose(tx_ready) && $past(irq_en))); // R4

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq); // R4

   AST_GAP_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      gap_busy |-> txd); // R5

endmodule

bind wkgap_uart_tx wkgap_uart_tx_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .baud_tick  (baud_tick),
   .wr_en      (wr_en),
   .wake_wr_en (wake_wr_en),
   .irq_en     (irq_en),
   .tx_ready   (tx_ready),
   .wake_q     (wake_q),
   .tx_irq     (tx_irq),
   .txd        (txd),
   .gap_busy   (gap_busy)
);

// File: tb/wkgap_uart_tx_tb_top.sv
`timescale 1ns/1ps
module wkgap_uart_tx_tb_top;

   localparam int DW   = 8;
   localparam int IDLE = 10;
   localparam int DIV  = 4;
   localparam int LOGN = 4096;
   localparam int NV   = 8;

   // vector layout: {addr_mode, wake, data}
   localparam logic [9:0] VEC [NV] = '{
      {1'b0, 1'b0, 8'hA5},
      {1'b0, 1'b0, 8'h01},
      {1'b0, 1'b0, 8'h80},
      {1'b1, 1'b0, 8'h3C},
      {1'b1, 1'b1, 8'hC3},
      {1'b0, 1'b1, 8'h00},
      {1'b1, 1'b1, 8'hFF},
      {1'b0, 1'b0, 8'h00}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          baud_tick = 1'b0;
   logic          addr_mode = 1'b0;
   logic          irq_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wake_wr_en = 1'b0;
   logic          wake_wr_val = 1'b0;
   logic          tx_ready, wake_q, tx_irq, txd;

   int checks = 0;
   int errors = 0;
   int dcnt = 0;
   logic tick_seen = 1'b0;
   logic lbits [LOGN];
   int lcnt = 0;

   always #2.5 clk = ~clk;

   wkgap_uart_tx #(.DATA_W(DW), .IDLE_BITS(IDLE), .ADDR_EN(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .addr_mode(addr_mode),
      .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .wake_wr_en(wake_wr_en),
      .wake_wr_val(wake_wr_val), .tx_ready(tx_ready), .wake_q(wake_q),
      .tx_irq(tx_irq), .txd(txd)
   );

   always @(negedge clk) begin
      if (!rst_n) begin
         dcnt = 0;
         baud_tick = 1'b0;
      end else begin
         dcnt = (dcnt + 1) % DIV;
         baud_tick = (dcnt == 0);
      end
   end

   always @(posedge clk) tick_seen <= baud_tick;

   always @(negedge clk) begin
      if (tick_seen && lcnt < LOGN) begin
         lbits[lcnt] = txd;
         lcnt = lcnt + 1;
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, got, exp);
      end
   endtask

   task automatic cpu_write(input logic [DW-1:0] d);
      @(negedge clk);
      wr_data = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic write_wake(input logic v);
      @(negedge clk);
      wake_wr_en = 1'b1;
      wake_wr_val = v;
      @(negedge clk);
      wake_wr_en = 1'b0;
   endtask

   task automatic wait_periods(input int n);
      repeat (n * DIV) @(negedge clk);
   endtask

   function automatic int find_zero(input int from);
      for (int i = from; i < lcnt; i++) begin
         if (lbits[i] == 1'b0) return i;
      end
      return -1;
   endfunction

   function automatic logic [10:0] grab(input int s, input int n);
      logic [10:0] v = '0;
      for (int k = 0; k < n; k++) begin
         if (s >= 0 && s + k < lcnt) v[k] = lbits[s + k];
      end
      return v;
   endfunction

   function automatic logic [10:0] exp_frame(input logic m, input logic w, input logic [7:0] d);
      logic [10:0] v = '0;
      v[0] = 1'b0;
      v[8:1] = d;
      if (m) begin
         v[9] = w;
         v[10] = 1'b1;
      end else begin
         v[9] = 1'b1;
      end
      return v;
   endfunction

   function automatic bit all_ones(input int from, input int to);
      for (int i = from; i < to && i < lcnt; i++) begin
         if (lbits[i] != 1'b1) return 1'b0;
      end
      return 1'b1;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int base, s, s2, n;
      logic m, w;
      logic [7:0] d;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1, "R1", "txd after reset", 32'(txd), 1);
      chk(tx_ready == 1'b1, "R1", "tx_ready after reset", 32'(tx_ready), 1);
      chk(tx_irq == 1'b0, "R1", "tx_irq after reset", 32'(tx_irq), 0);
      chk(wake_q == 1'b0, "R1", "wake_q after reset", 32'(wake_q), 0);
      wait_periods(2);

      // table walk: R2 / R5 / R7
      for (int v = 0; v < NV; v++) begin
         m = VEC[v][9];
         w = VEC[v][8];
         d = VEC[v][7:0];
         @(negedge clk);
         addr_mode = m;
         if (w) write_wake(1'b1);
         base = lcnt;
         cpu_write(d);
         wait_periods(18);
         if (!m && w) begin
            chk(all_ones(base, lcnt), "R5", "idle gap sends no character", 0, 0);
         end else begin
            n = m ? 11 : 10;
            s = find_zero(base);
            chk(grab(s, n) == exp_frame(m, w, d), m ? "R7" : "R2", "frame bits",
                32'(grab(s, n)), 32'(exp_frame(m, w, d)));
         end
         chk(wake_q == 1'b0 && tx_ready == 1'b1, m ? "R7" : "R4", "wake cleared after transfer",
             32'({wake_q, tx_ready}), 32'h1);
      end

      // R4: ready, wake clear and interrupt on one edge
      addr_mode = 1'b0;
      irq_en = 1'b1;
      write_wake(1'b1);
      base = lcnt;
      cpu_write(8'h55);
      chk(tx_ready == 1'b0, "R3", "ready low after write", 32'(tx_ready), 0);
      @(negedge clk);
      chk({tx_ready, wake_q, tx_irq} == 3'b101, "R4", "ready/wake/irq at transfer",
          32'({tx_ready, wake_q, tx_irq}), 32'h5);
      @(negedge clk);
      chk(tx_irq == 1'b0, "R4", "irq single cycle", 32'(tx_irq), 0);
      wait_periods(14);
      chk(all_ones(base, lcnt), "R5", "dummy 0x55 not on line", 0, 0);

      // R4: interrupt suppressed when disabled
      irq_en = 1'b0;
      cpu_write(8'h0F);
      @(negedge clk);
      chk(tx_irq == 1'b0 && tx_ready == 1'b1, "R4", "no irq when disabled",
          32'({tx_irq, tx_ready}), 32'h1);
      wait_periods(16);

      // R3 / R6: back-to-back and dropped write
      base = lcnt;
      cpu_write(8'h96);
      @(negedge clk);
      cpu_write(8'h3B);
      cpu_write(8'hE7);
      chk(tx_ready == 1'b0, "R3", "ready stays low while held", 32'(tx_ready), 0);
      wait_periods(30);
      s = find_zero(base);
      chk(grab(s, 10) == exp_frame(1'b0, 1'b0, 8'h96), "R2", "first frame",
          32'(grab(s, 10)), 32'(exp_frame(1'b0, 1'b0, 8'h96)));
      chk(s >= 0 && grab(s + 10, 10) == exp_frame(1'b0, 1'b0, 8'h3B), "R6",
          "second frame back-to-back", 32'(grab(s + 10, 10)), 32'(exp_frame(1'b0, 1'b0, 8'h3B)));
      chk(s >= 0 && all_ones(s + 20, lcnt), "R3", "dropped write not sent", 0, 0);

      // R5 / R6: gap after a frame, then address back-to-back
      base = lcnt;
      cpu_write(8'h81);
      @(negedge clk);
      write_wake(1'b1);
      cpu_write(8'h00);
      for (int i = 0; i < 400 && !tx_ready; i++) @(negedge clk);
      cpu_write(8'h42);
      wait_periods(40);
      s = find_zero(base);
      chk(grab(s, 10) == exp_frame(1'b0, 1'b0, 8'h81), "R2", "frame before gap",
          32'(grab(s, 10)), 32'(exp_frame(1'b0, 1'b0, 8'h81)));
      chk(s >= 0 && all_ones(s + 10, s + 10 + IDLE), "R5", "gap holds line high", 0, 0);
      chk(s >= 0 && grab(s + 10 + IDLE, 10) == exp_frame(1'b0, 1'b0, 8'h42), "R6",
          "address right after gap", 32'(grab(s + 10 + IDLE, 10)), 32'(exp_frame(1'b0, 1'b0, 8'h42)));

      // R8: wake write on the transfer edge
      addr_mode = 1'b1;
      base = lcnt;
      cpu_write(8'h5A);
      wake_wr_en = 1'b1;
      wake_wr_val = 1'b1;
      @(negedge clk);
      wake_wr_en = 1'b0;
      chk(wake_q == 1'b1 && tx_ready == 1'b1, "R8", "software wake kept",
          32'({wake_q, tx_ready}), 32'h3);
      cpu_write(8'hA6);
      wait_periods(32);
      s = find_zero(base);
      chk(grab(s, 11) == exp_frame(1'b1, 1'b0, 8'h5A), "R8", "old wake used on collision",
          32'(grab(s, 11)), 32'(exp_frame(1'b1, 1'b0, 8'h5A)));
      s2 = (s >= 0) ? s + 11 : -1;
      chk(grab(s2, 11) == exp_frame(1'b1, 1'b1, 8'hA6), "R7", "address bit set on next",
          32'(grab(s2, 11)), 32'(exp_frame(1'b1, 1'b1, 8'hA6)));
      chk(wake_q == 1'b0, "R7", "wake cleared after address frame", 32'(wake_q), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule